// File: doc/BRIEF.md
# Lazy-Reduction Montgomery Multiplier

This block multiplies two residues in Montgomery form and reduces the product by the Montgomery method. The radix is R = 2^WIDTH, the modulus m is odd, and a precomputed constant m' satisfies m·m' ≡ −1 (mod R). The datapath is two bits wider than the modulus. With R' = R/4, both operands may be anywhere below 2R', and every result is again below 2R'. Results can therefore be fed straight into the next multiply with no final subtraction.

The work runs on one half-width multiplier (WIDTH/2 × WIDTH/2) that is reused across the sequence, in three steps:
- The full product p = x·y takes four half products.
- The low-half product b = p·m' mod R takes three.
- The high part of b·m takes three or four.

In the reduced mode (`DERIVE_LOW = 1`) the lowest partial product b0·m0 is not multiplied. It is derived instead as −(p + (b0·m1 + b1·m0)·2^(WIDTH/2)) mod R, because the low half of p + b·m must be zero. A build-time option (`CANON_OUT = 1`) adds the classic final step that subtracts m once when the result is not below m.

A request is accepted on a clock edge where `start_i` is high and the block is idle. Operands, modulus and constant are captured on that edge. A one-cycle `done_o` pulse marks the result.

Top module: `lazy_mont_mul`

## Requirements
- R1: While reset is held, `done_o` and `busy_o` are 0 and `result_o` is 0.
- R2: For an odd modulus below R' and operands below 2R', the result r satisfies r·2^WIDTH ≡ x·y (mod m).
- R3: In lazy mode every result is below 2R' and below R' + m.
- R4: With `DERIVE_LOW = 1`, `done_o` is high for exactly one cycle, in the cycle after the 11th rising edge following the accepting edge.
- R5: A `start_i` seen while `busy_o` is high is ignored: the running result and its timing are unchanged.
- R6: With `CANON_OUT = 1`, operands below m give the exact value x·y·R⁻¹ mod m, below m. Any other legal operands give a congruent result below R'.
- R7: Reduced mode and full four-product mode give bit-identical results for the same inputs.
- R8: With `DERIVE_LOW = 0` the extra product adds one cycle, so `done_o` follows the 12th edge after acceptance.
- R9: `result_o` holds its value from one `done_o` pulse until the next.
- R10: A zero operand gives a zero result.
- R11: Operands at the top of the range (2R' − 1) still give a congruent, in-range result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request; accepted only when idle |
| op_a_i | input | WIDTH | First operand, below 2R' |
| op_b_i | input | WIDTH | Second operand, below 2R' |
| mod_i | input | WIDTH | Odd modulus, below R' |
| mod_inv_i | input | WIDTH | m' with m·m' ≡ −1 mod 2^WIDTH |
| busy_o | output | 1 | A request is in progress |
| done_o | output | 1 | One-cycle pulse: `result_o` valid |
| result_o | output | WIDTH | Montgomery product |

## Verification
Each kind of internal fault shows at the ports in a distinct way:
- **Wrong accumulator or partial-product selection:** the result is not congruent at the very next `done_o`, or it escapes the 2R' bound. This is caught on that one result.
- **Wrong derived low term:** the reduced-mode instance parts from the full-mode instance on the first request where b0·m0 is nonzero.
- **Sequencer fault:** `done_o` arrives a cycle early or late, pulses twice, or a mid-run `start_i` changes the answer. This is visible within the same request.

// File: rtl/mont_pkg.sv
package mont_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_P00, ST_P01, ST_P10, ST_P11,
    ST_Q00, ST_Q01, ST_Q10,
    ST_M11, ST_M01, ST_M10, ST_M00,
    ST_FIN
  } mont_state_e;
endpackage

// File: rtl/mont_half_mul.sv
module mont_half_mul #(
  parameter int HALF = 32
) (
  input  logic [HALF-1:0]   a_i,
  input  logic [HALF-1:0]   b_i,
  output logic [2*HALF-1:0] p_o
);
  assign p_o = a_i * b_i;
endmodule

// File: rtl/mont_seq_ctrl.sv
module mont_seq_ctrl import mont_pkg::*; #(
  parameter bit DERIVE_LOW = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output mont_state_e state_o,
  output logic        busy_o
);
  mont_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start_i) state_d = ST_P00;
      ST_P00:  state_d = ST_P01;
      ST_P01:  state_d = ST_P10;
      ST_P10:  state_d = ST_P11;
      ST_P11:  state_d = ST_Q00;
      ST_Q00:  state_d = ST_Q01;
      ST_Q01:  state_d = ST_Q10;
      ST_Q10:  state_d = ST_M11;
      ST_M11:  state_d = ST_M01;
      ST_M01:  state_d = ST_M10;
      ST_M10:  state_d = DERIVE_LOW ? ST_FIN : ST_M00;
      ST_M00:  state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
  assign busy_o  = (state_q != ST_IDLE);
endmodule

// File: rtl/mont_fold.sv
module mont_fold #(
  parameter int WIDTH = 64
) (
  input  logic [2*WIDTH-1:0] prod_i,
  input  logic [WIDTH-1:0]   hi_i,
  input  logic [WIDTH:0]     cross_i,
  input  logic [WIDTH-1:0]   low_i,
  output logic [WIDTH-1:0]   r_o
);
  localparam int HALF = WIDTH / 2;
  localparam int DW   = 2 * WIDTH;

  logic [DW-1:0]    sum;
  logic [WIDTH-1:0] unused_low;

  // true sum stays below 2^(2*WIDTH-1), so DW bits lose nothing
  assign sum = prod_i
             + {hi_i, {WIDTH{1'b0}}}
             + (DW'(cross_i) << HALF)
             + DW'(low_i);
  assign r_o        = sum[DW-1:WIDTH];
  assign unused_low = sum[WIDTH-1:0];
endmodule

// File: rtl/lazy_mont_mul.sv
module lazy_mont_mul import mont_pkg::*; #(
  parameter int WIDTH      = 64,
  parameter bit DERIVE_LOW = 1'b1,
  parameter bit CANON_OUT  = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [WIDTH-1:0] mod_i,
  input  logic [WIDTH-1:0] mod_inv_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] result_o
);
  localparam int HALF = WIDTH / 2;
  localparam int DW   = 2 * WIDTH;

  mont_state_e      state;
  logic             busy;
  logic [WIDTH-1:0] x_q, y_q, m_q, mi_q;
  logic [DW-1:0]    p_q;
  logic [WIDTH-1:0] b_q, hi_q;
  logic [WIDTH:0]   cross_q;
  logic [HALF-1:0]  mul_a, mul_b;
  logic [WIDTH-1:0] prod;
  logic [WIDTH-1:0] low_w, fold_r, res_d, res_q;
  logic             done_q;

  mont_seq_ctrl #(.DERIVE_LOW(DERIVE_LOW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .state_o (state),
    .busy_o  (busy)
  );

  mont_half_mul #(.HALF(HALF)) u_mul (
    .a_i (mul_a),
    .b_i (mul_b),
    .p_o (prod)
  );

  // operand routing for the shared multiplier
  always_comb begin
    mul_a = '0;
    mul_b = '0;
    case (state)
      ST_P00: begin mul_a = x_q[HALF-1:0];     mul_b = y_q[HALF-1:0];      end
      ST_P01: begin mul_a = x_q[HALF-1:0];     mul_b = y_q[WIDTH-1:HALF];  end
      ST_P10: begin mul_a = x_q[WIDTH-1:HALF]; mul_b = y_q[HALF-1:0];      end
      ST_P11: begin mul_a = x_q[WIDTH-1:HALF]; mul_b = y_q[WIDTH-1:HALF];  end
      ST_Q00: begin mul_a = p_q[HALF-1:0];     mul_b = mi_q[HALF-1:0];     end
      ST_Q01: begin mul_a = p_q[HALF-1:0];     mul_b = mi_q[WIDTH-1:HALF]; end
      ST_Q10: begin mul_a = p_q[WIDTH-1:HALF]; mul_b = mi_q[HALF-1:0];     end
      ST_M11: begin mul_a = b_q[WIDTH-1:HALF]; mul_b = m_q[WIDTH-1:HALF];  end
      ST_M01: begin mul_a = b_q[HALF-1:0];     mul_b = m_q[WIDTH-1:HALF];  end
      ST_M10: begin mul_a = b_q[WIDTH-1:HALF]; mul_b = m_q[HALF-1:0];      end
      ST_M00: begin mul_a = b_q[HALF-1:0];     mul_b = m_q[HALF-1:0];      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q     <= '0;
      y_q     <= '0;
      m_q     <= '0;
      mi_q    <= '0;
      p_q     <= '0;
      b_q     <= '0;
      hi_q    <= '0;
      cross_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          x_q  <= op_a_i;
          y_q  <= op_b_i;
          m_q  <= mod_i;
          mi_q <= mod_inv_i;
        end
        ST_P00: p_q <= DW'(prod);
        ST_P01, ST_P10: p_q <= p_q + (DW'(prod) << HALF);
        ST_P11: p_q <= p_q + {prod, {WIDTH{1'b0}}};
        ST_Q00: b_q <= prod;
        ST_Q01, ST_Q10: b_q <= b_q + {prod[HALF-1:0], {HALF{1'b0}}};
        ST_M11: hi_q <= prod;
        ST_M01: cross_q <= {1'b0, prod};
        ST_M10: cross_q <= cross_q + {1'b0, prod};
        default: ;
      endcase
    end
  end

  generate
    if (DERIVE_LOW) begin : g_low_derived
      // low half of p + b*m is zero, so b0*m0 follows from what is known
      assign low_w = '0 - (p_q[WIDTH-1:0] + {cross_q[HALF-1:0], {HALF{1'b0}}});
    end else begin : g_low_mult
      logic [WIDTH-1:0] low_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)              low_q <= '0;
        else if (state == ST_M00) low_q <= prod;
      end
      assign low_w = low_q;
    end
  endgenerate

  mont_fold #(.WIDTH(WIDTH)) u_fold (
    .prod_i  (p_q),
    .hi_i    (hi_q),
    .cross_i (cross_q),
    .low_i   (low_w),
    .r_o     (fold_r)
  );

  generate
    if (CANON_OUT) begin : g_canon
      assign res_d = (fold_r >= m_q) ? fold_r - m_q : fold_r;
    end else begin : g_lazy
      assign res_d = fold_r;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (state == ST_FIN);
      if (state == ST_FIN) res_q <= res_d;
    end
  end

  assign busy_o   = busy;
  assign done_o   = done_q;
  assign result_o = res_q;
endmodule

// File: rtl/mont_mul_checker.sv
module mont_mul_checker #(
  parameter int WIDTH     = 64,
  parameter bit CANON_OUT = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_i,
  input logic             done_i,
  input logic [WIDTH-1:0] result_i
);
  localparam int LIM_SH = CANON_OUT ? WIDTH - 2 : WIDTH - 1;

  a_r3_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> ((result_i >> LIM_SH) == '0));

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r4_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> $past(busy_i));

  a_r5_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  a_r9_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(result_i));
endmodule

bind lazy_mont_mul mont_mul_checker #(.WIDTH(WIDTH), .CANON_OUT(CANON_OUT)) u_mont_mul_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_i   (busy_o),
  .done_i   (done_o),
  .result_i (result_o)
);

// File: tb/lazy_mont_mul_bench.sv
`timescale 1ns/1ps
module lazy_mont_mul_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0, md = '0, mi = '0;
  logic         bz, bf, bs, dz, df, ds;
  logic [W-1:0] rz, rf, rs;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lazy_mont_mul #(.WIDTH(W), .DERIVE_LOW(1'b1), .CANON_OUT(1'b0)) u_lazy_mont_mul (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_a_i(op_a), .op_b_i(op_b),
    .mod_i(md), .mod_inv_i(mi), .busy_o(bz), .done_o(dz), .result_o(rz));
  lazy_mont_mul #(.WIDTH(W), .DERIVE_LOW(1'b0), .CANON_OUT(1'b0)) u_lazy_mont_mul_full (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_a_i(op_a), .op_b_i(op_b),
    .mod_i(md), .mod_inv_i(mi), .busy_o(bf), .done_o(df), .result_o(rf));
  lazy_mont_mul #(.WIDTH(W), .DERIVE_LOW(1'b1), .CANON_OUT(1'b1)) u_lazy_mont_mul_strict (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_a_i(op_a), .op_b_i(op_b),
    .mod_i(md), .mod_inv_i(mi), .busy_o(bs), .done_o(ds), .result_o(rs));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int inv_of(input int m);
    for (int i = 1; i < 256; i += 2)
      if (((m * i) & 255) == 255) return i;
    return 0;
  endfunction

  function automatic int exact_of(input int a, input int b, input int m);
    for (int e = 0; e < m; e++)
      if (((e * 256) % m) == ((a * b) % m)) return e;
    return -1;
  endfunction

  task automatic run_op(input int a, input int b, input int m, input bit poke);
    int tz = 0, tf = 0, ts = 0, cz = 0, cf = 0, cs = 0;
    int hz = 0, hf = 0, hs = 0;
    int pm, ex;
    @(negedge clk);
    op_a = W'(a); op_b = W'(b); md = W'(m); mi = W'(inv_of(m)); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 1; j <= 14; j++) begin
      if (poke && j == 3) begin
        start = 1'b1; op_a = W'((a ^ 85) & 127); op_b = W'((b + 19) & 127);
      end
      if (poke && j == 4) start = 1'b0;
      @(negedge clk);
      if (dz) begin tz = j; cz++; hz = int'(rz); end
      if (df) begin tf = j; cf++; hf = int'(rf); end
      if (ds) begin ts = j; cs++; hs = int'(rs); end
    end
    pm = (a * b) % m;
    chk(tz == 11 && cz == 1, "R4 reduced-mode done timing", tz, 11);
    chk(tf == 12 && cf == 1, "R8 full-mode done timing", tf, 12);
    chk(ts == 11 && cs == 1, "R4 canonical done timing", ts, 11);
    chk(int'(rz) == hz && int'(rf) == hf && int'(rs) == hs, "R9 result hold", int'(rz), hz);
    chk(((hz * 256) % m) == pm, "R2 congruence", (hz * 256) % m, pm);
    chk(hz < 128 && hz < 64 + m, "R3 range", hz, 64 + m);
    chk(hf == hz, "R7 full mode matches reduced", hf, hz);
    if (a < m && b < m) begin
      ex = exact_of(a, b, m);
      chk(hs == ex, poke ? "R5 start ignored while busy" : "R6 canonical exact", hs, ex);
    end else begin
      chk(((hs * 256) % m) == pm && hs < 64, "R6 canonical congruent", hs, pm);
    end
    if (a == 0 || b == 0) chk(hz == 0 && hs == 0, "R10 zero operand", hz, 0);
    if (a == 127 && b == 127) chk(hz < 128 && ((hz * 256) % m) == pm, "R11 top operands", hz, pm);
  endtask

  initial begin
    #(1_500_000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int mods[4] = '{3, 37, 61, 63};
    repeat (3) @(negedge clk);
    chk(!dz && !bz && rz == 0 && !df && !bf && rf == 0 && !ds && !bs && rs == 0,
        "R1 reset state", int'(rz), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(50, 40, 61, 1'b1);
    run_op(127, 127, 63, 1'b0);
    run_op(127, 127, 3, 1'b0);
    run_op(0, 99, 37, 1'b0);
    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 128; a += 9)
        for (int b = 0; b < 128; b += 7)
          run_op(a, b, mods[k], 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule